// File: doc/BRIEF.md
# Two-Register-Compare Multicycle Byte Core

This block is a small multicycle processor for a 16-opcode instruction set with four 8-bit general registers, a 16-bit instruction pointer and a 16-bit return-stack pointer. It has no flag register. Conditional branches and conditional calls compare two registers directly. Subroutine linkage uses a descending stack of two-byte slots that lives in ordinary memory.

The core drives a byte-wide synchronous memory. Read data returns on the cycle after the read strobe. Addresses 0xFFF0 to 0xFFFF never reach that memory. A load from 0xFFFF takes a byte from an input port with a valid/acknowledge pair. A store to 0xFFFF presents the byte on an output port for one cycle. Opcode 0 stops the core, and the core stays stopped until reset.

Top module: `tc_core`

## Requirements
- R1: After reset the core raises no halted flag, the instruction pointer is 0 and the stack pointer is 0xFFF0, so the first bus cycle is a read of address 0.
- R2: An instruction byte holds the opcode in bits [7:4], RX in bits [3:2] and RY in bits [1:0]. Opcodes 0xA to 0xF are followed by a 16-bit address, high byte first. All other opcodes are one byte long.
- R3: Opcodes 2, 3, 4 and 5 replace RX with RX shifted left, shifted right (zero fill), rotated left or rotated right, each by one bit.
- R4: Opcodes 6, 7, 8 and 9 replace RX with ~(RX&RY), RX&RY, RX|RY or RX^RY.
- R5: Opcode 0xA loads RX from the address. Opcode 0xB writes RX to the address. Ordinary addresses use the memory bus.
- R6: A load from 0xFFFF waits until in_valid is high, then takes in_data and pulses in_ack for exactly one cycle.
- R7: A store to 0xFFFF pulses out_valid for one cycle with RX on out_data, and it asserts no memory write.
- R8: The core never asserts mem_re or mem_we with an address of 0xFFF0 or above. A load from a reserved address other than 0xFFFF yields 0, and a store to one is dropped.
- R9: Opcode 0xC jumps to the address when RX equals RY. Opcode 0xD jumps when they differ. Otherwise execution falls through.
- R10: Opcode 0xE (equal) or 0xF (unequal), when its condition holds, subtracts 2 from the stack pointer. It then stores the address of the next instruction there, high byte at the lower address, and jumps. When the condition fails it touches no memory.
- R11: Opcode 1 reloads the instruction pointer from the two bytes at the stack pointer and adds 2 to the stack pointer, so nested calls return in order.
- R12: Opcode 0 holds halted high with no memory or port activity until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid the cycle after mem_re |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| in_data | input | 8 | Input port byte |
| in_valid | input | 1 | Input port byte available |
| in_ack | output | 1 | Input byte consumed this cycle |
| out_data | output | 8 | Output port byte |
| out_valid | output | 1 | Output byte valid this cycle |
| halted | output | 1 | Core stopped by opcode 0 |

## Verification
The bench goes after rotate carry-around, which a wrong design would turn into a plain shift, and after the byte order of both the address operand and the saved return pointer, which a wrong design would swap. It tests calls whose condition fails, which must leave the stack bytes untouched, and nested calls, which expose a stack pointer that steps by one instead of two. It also loads and stores reserved addresses, which must never reach memory and must read back as 0. Finally, it holds the input port off for many cycles to catch a core that does not wait for the input byte.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int DW = 8;
  localparam int AW = 16;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_RET   = 4'h1;
  localparam logic [3:0] OP_SHL   = 4'h2;
  localparam logic [3:0] OP_SHR   = 4'h3;
  localparam logic [3:0] OP_ROL   = 4'h4;
  localparam logic [3:0] OP_ROR   = 4'h5;
  localparam logic [3:0] OP_NAND  = 4'h6;
  localparam logic [3:0] OP_AND   = 4'h7;
  localparam logic [3:0] OP_OR    = 4'h8;
  localparam logic [3:0] OP_XOR   = 4'h9;
  localparam logic [3:0] OP_LOAD  = 4'hA;
  localparam logic [3:0] OP_STORE = 4'hB;
  localparam logic [3:0] OP_BEQ   = 4'hC;
  localparam logic [3:0] OP_BNE   = 4'hD;
  localparam logic [3:0] OP_CEQ   = 4'hE;
  localparam logic [3:0] OP_CNE   = 4'hF;

  typedef enum logic [3:0] {
    S_F0, S_D0, S_F1, S_D1, S_F2, S_D2,
    S_EX, S_LD, S_IN, S_C2, S_R1, S_R2, S_HALT
  } tc_state_e;

  function automatic logic has_addr(input logic [3:0] op);
    return op >= OP_LOAD;
  endfunction

  function automatic logic is_alu(input logic [3:0] op);
    return (op >= OP_SHL) && (op <= OP_XOR);
  endfunction

  function automatic logic [DW-1:0] alu_calc(input logic [3:0] op,
                                             input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      OP_SHL:  return {a[DW-2:0], 1'b0};
      OP_SHR:  return {1'b0, a[DW-1:1]};
      OP_ROL:  return {a[DW-2:0], a[DW-1]};
      OP_ROR:  return {a[0], a[DW-1:1]};
      OP_NAND: return ~(a & b);
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/tc_alu.sv
module tc_alu
  import tc_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          same
);
  assign res  = alu_calc(op, a, b);
  assign same = (a == b);
endmodule

// File: rtl/tc_regs.sv
module tc_regs #(
  parameter int NREG = 4,
  parameter int W    = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [NREG-1:0][W-1:0] bank;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && (wsel == SW'(g))) q <= wdata;
    end
    assign bank[g] = q;
  end

  assign rd_a = bank[sel_a];
  assign rd_b = bank[sel_b];
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter int          NREG     = 4,
  parameter logic [15:0] RP_RESET = 16'hFFF0,
  parameter logic [15:0] IO_LOW   = 16'hFFF0,
  parameter logic [15:0] IO_PORT  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_re,
  output logic          mem_we,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ack,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  localparam int SW = $clog2(NREG);
  localparam logic [AW-1:0] SLOT = AW'(2);
  localparam logic [AW-1:0] ONE  = AW'(1);

  tc_state_e     state;
  logic [AW-1:0] ip, rp, op_addr;
  logic [DW-1:0] ir, tmp;

  logic [3:0]    op;
  logic [SW-1:0] rx, ry;
  logic [DW-1:0] rx_val, ry_val, alu_res, wr_data;
  logic          same, wr_en;

  assign op = ir[7:4];
  assign rx = ir[2+:SW];
  assign ry = ir[0+:SW];

  // named events for the assertions
  logic ev_cond, ev_rsv, ev_call, ev_ret_end;
  assign ev_cond    = (op == OP_BEQ || op == OP_CEQ) ? same : !same;
  assign ev_rsv     = (op_addr >= IO_LOW);
  assign ev_call    = (state == S_EX) && (op == OP_CEQ || op == OP_CNE) && ev_cond;
  assign ev_ret_end = (state == S_R2);

  tc_regs #(.NREG(NREG), .W(DW)) u_regs (
    .clk(clk), .we(wr_en), .wsel(rx), .wdata(wr_data),
    .sel_a(rx), .sel_b(ry), .rd_a(rx_val), .rd_b(ry_val)
  );

  tc_alu u_alu (.op(op), .a(rx_val), .b(ry_val), .res(alu_res), .same(same));

  always_comb begin
    mem_addr  = ip;
    mem_wdata = rx_val;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    out_valid = 1'b0;
    in_ack    = 1'b0;
    wr_en     = 1'b0;
    wr_data   = alu_res;
    case (state)
      S_F0, S_F1, S_F2: mem_re = 1'b1;
      S_EX: begin
        case (op)
          OP_RET: begin mem_addr = rp; mem_re = 1'b1; end
          OP_LOAD: begin
            mem_addr = op_addr;
            mem_re   = !ev_rsv;
            if (ev_rsv && op_addr != IO_PORT) begin wr_en = 1'b1; wr_data = '0; end
          end
          OP_STORE: begin
            mem_addr  = op_addr;
            mem_we    = !ev_rsv;
            out_valid = (op_addr == IO_PORT);
          end
          OP_CEQ, OP_CNE: if (ev_cond) begin
            mem_addr  = rp - SLOT;
            mem_we    = 1'b1;
            mem_wdata = ip[AW-1:DW];
          end
          default: wr_en = is_alu(op);
        endcase
      end
      S_LD: begin wr_en = 1'b1; wr_data = mem_rdata; end
      S_IN: begin in_ack = in_valid; wr_en = in_valid; wr_data = in_data; end
      S_C2: begin mem_addr = rp + ONE; mem_we = 1'b1; mem_wdata = ip[DW-1:0]; end
      S_R1: begin mem_addr = rp + ONE; mem_re = 1'b1; end
      default: ;
    endcase
  end

  assign out_data = rx_val;
  assign halted   = (state == S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_F0;
      ip      <= '0;
      rp      <= RP_RESET;
      ir      <= '0;
      op_addr <= '0;
      tmp     <= '0;
    end else begin
      case (state)
        S_F0: state <= S_D0;
        S_D0: begin
          ir    <= mem_rdata;
          ip    <= ip + ONE;
          state <= has_addr(mem_rdata[7:4]) ? S_F1 : S_EX;
        end
        S_F1: state <= S_D1;
        S_D1: begin op_addr[AW-1:DW] <= mem_rdata; ip <= ip + ONE; state <= S_F2; end
        S_F2: state <= S_D2;
        S_D2: begin op_addr[DW-1:0] <= mem_rdata; ip <= ip + ONE; state <= S_EX; end
        S_EX: begin
          state <= S_F0;
          case (op)
            OP_HALT: state <= S_HALT;
            OP_RET:  state <= S_R1;
            OP_LOAD: if (!ev_rsv) state <= S_LD;
                     else if (op_addr == IO_PORT) state <= S_IN;
            OP_BEQ, OP_BNE: if (ev_cond) ip <= op_addr;
            OP_CEQ, OP_CNE: if (ev_cond) begin rp <= rp - SLOT; state <= S_C2; end
            default: ;
          endcase
        end
        S_LD: state <= S_F0;
        S_IN: if (in_valid) state <= S_F0;
        S_C2: begin ip <= op_addr; state <= S_F0; end
        S_R1: begin tmp <= mem_rdata; state <= S_R2; end
        S_R2: begin ip <= {tmp, mem_rdata}; rp <= rp + SLOT; state <= S_F0; end
        S_HALT: state <= S_HALT;
        default: state <= S_F0;
      endcase
    end
  end

  // R8: one bus direction at a time, reserved window never on the bus
  p_bus_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  p_no_rsv_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (mem_addr < IO_LOW));
  // R7: output port strobe never pairs with a memory write
  p_out_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_we);
  // R6: input taken only while offered and only while waiting for it
  p_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |-> (in_valid && state == S_IN));
  // R10: a taken call moves the stack pointer down one slot
  p_call_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> (rp == $past(rp) - SLOT));
  // R11: return moves the stack pointer up one slot
  p_ret_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ret_end |=> (rp == $past(rp) + SLOT));
  // R12: halted sticks and is silent
  p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_re || mem_we || out_valid || in_ack));
endmodule

// File: tb/sim_tc_core.sv
module sim_tc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_re, mem_we;
  logic [7:0]  in_data = 8'h00;
  logic        in_valid = 1'b1;
  logic        in_ack;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        halted;

  always #5 clk = ~clk;

  tc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_we(mem_we),
    .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_valid(out_valid), .halted(halted)
  );

  logic [7:0] mem [0:4095];
  logic [7:0] outv [0:15];
  int outn, rsv_hits, halt_acc, ack_n;
  int nchk = 0, nerr = 0, pc;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      outn <= 0; rsv_hits <= 0; halt_acc <= 0; ack_n <= 0;
    end else begin
      if (out_valid && outn < 16) begin outv[outn] <= out_data; outn <= outn + 1; end
      if ((mem_re || mem_we) && mem_addr >= 16'hFFF0) rsv_hits <= rsv_hits + 1;
      if (halted && (mem_re || mem_we || out_valid || in_ack)) halt_acc <= halt_acc + 1;
      if (in_ack) ack_n <= ack_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_alu(input int op, input int a, input int b);
    case (op)
      2: return 8'((a * 2) % 256);
      3: return 8'(a / 2);
      4: return 8'((a * 2) % 256 + a / 128);
      5: return 8'(a / 2 + (a % 2) * 128);
      6: return 8'(255 - (a & b));
      7: return 8'(a & b);
      8: return 8'(a | b);
      default: return 8'(a ^ b);
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
    pc = 0;
  endtask
  task automatic emit(input logic [7:0] b);
    mem[pc] <= b; pc++;
  endtask
  task automatic put3(input int op, input int x, input int y, input logic [15:0] a);
    emit(8'(op * 16 + x * 4 + y)); emit(a[15:8]); emit(a[7:0]);
  endtask
  task automatic put_loads();
    for (int i = 0; i < 4; i++) put3(10, i, 0, 16'h0100 + 16'(i));
  endtask

  task automatic start_run(input bit check_boot);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    if (check_boot) chk("R1 halted in reset", halted, 0);
    rst_n = 1'b1;
    #1;
    if (check_boot) begin
      chk("R1 first read strobe", mem_re, 1);
      chk("R1 first address", mem_addr, 0);
    end
  endtask

  task automatic wait_halt();
    int n = 0;
    while (!halted && n < 5000) begin @(negedge clk); n++; end
    if (!halted) begin
      nchk++; nerr++;
      $display("FAIL R12 watchdog actual=running expected=halted");
    end
  endtask

  initial begin
    int seed = 32'h1D5;
    void'($urandom(seed));

    // R3/R4/R5 random single-op programs
    for (int t = 0; t < 30; t++) begin
      logic [7:0] d [4];
      int op = 2 + int'($urandom % 8);
      int x = int'($urandom % 4), y = int'($urandom % 4);
      logic [7:0] e;
      clear_mem();
      for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
      if (t == 0) begin op = 4; x = 1; d[1] = 8'h81; end
      if (t == 1) begin op = 5; x = 2; d[2] = 8'h01; end
      for (int i = 0; i < 4; i++) mem[256 + i] <= d[i];
      put_loads();
      emit(8'(op * 16 + x * 4 + y));
      put3(11, x, 0, 16'hFFFF);
      put3(11, x, 0, 16'h0200);
      emit(8'h00);
      e = ref_alu(op, int'(d[x]), int'(d[y]));
      start_run(t == 0);
      wait_halt();
      @(negedge clk);
      chk("R7 one output", outn, 1);
      chk(op < 6 ? "R3 shift/rotate (R2 fields)" : "R4 logic (R2 fields)", outv[0], e);
      chk("R5 store to memory", mem[12'h200], e);
    end

    // R9 branches
    for (int t = 0; t < 16; t++) begin
      int op = (t % 2 == 0) ? 12 : 13;
      logic [7:0] a = 8'($urandom), b;
      bit take;
      b = (t % 4 < 2) ? a : 8'($urandom);
      take = (op == 12) ? (a == b) : (a != b);
      clear_mem();
      mem[256] <= a; mem[257] <= b; mem[258] <= 8'h11; mem[259] <= 8'h22;
      put_loads();
      put3(op, 0, 1, 16'h0040);
      put3(11, 2, 0, 16'hFFFF); emit(8'h00);
      pc = 16'h40;
      put3(11, 3, 0, 16'hFFFF); emit(8'h00);
      start_run(0);
      wait_halt();
      @(negedge clk);
      chk("R9 branch outcome (R2 address order)", outv[0], take ? 8'h22 : 8'h11);
    end

    // R10/R11 single calls, taken and not taken
    for (int t = 0; t < 4; t++) begin
      int op = (t % 2 == 0) ? 14 : 15;
      logic [7:0] a = 8'h3C, b;
      bit take;
      b = (t < 2) ? a : 8'h3D;
      take = (op == 14) ? (a == b) : (a != b);
      clear_mem();
      mem[256] <= a; mem[257] <= b; mem[258] <= 8'h11; mem[259] <= 8'h22;
      mem[12'hFEE] <= 8'hA5; mem[12'hFEF] <= 8'hA5;
      put_loads();
      put3(12, 0, 0, 16'h0300);
      pc = 16'h300;
      put3(op, 0, 1, 16'h0380);
      put3(11, 2, 0, 16'hFFFF); emit(8'h00);
      pc = 16'h380;
      put3(11, 3, 0, 16'hFFFF); emit(8'h10);
      start_run(0);
      wait_halt();
      @(negedge clk);
      chk("R10 output count", outn, take ? 2 : 1);
      chk("R10 first output", outv[0], take ? 8'h22 : 8'h11);
      if (take) chk("R11 returns after call", outv[1], 8'h11);
      chk("R10 saved high byte at lower address", mem[12'hFEE], take ? 8'h03 : 8'hA5);
      chk("R10 saved low byte", mem[12'hFEF], take ? 8'h03 : 8'hA5);
    end

    // R11 nested calls
    clear_mem();
    mem[256] <= 8'h00; mem[257] <= 8'h77; mem[258] <= 8'h11; mem[259] <= 8'h22;
    put_loads();
    put3(12, 0, 0, 16'h0300);
    pc = 16'h300; put3(14, 0, 0, 16'h0380); put3(11, 2, 0, 16'hFFFF); emit(8'h00);
    pc = 16'h380; put3(14, 0, 0, 16'h03C0); put3(11, 3, 0, 16'hFFFF); emit(8'h10);
    pc = 16'h3C0; put3(11, 1, 0, 16'hFFFF); emit(8'h10);
    start_run(0);
    wait_halt();
    @(negedge clk);
    chk("R11 nested count", outn, 3);
    chk("R11 nested order 0", outv[0], 8'h77);
    chk("R11 nested order 1", outv[1], 8'h22);
    chk("R11 nested order 2", outv[2], 8'h11);
    chk("R10 inner slot high", mem[12'hFEC], 8'h03);
    chk("R10 inner slot low", mem[12'hFED], 8'h83);

    // R8 reserved window
    clear_mem();
    mem[256] <= 8'h01; mem[257] <= 8'h7E; mem[258] <= 8'h11; mem[259] <= 8'h22;
    put_loads();
    put3(10, 1, 0, 16'hFFF5);
    put3(11, 2, 0, 16'hFFF3);
    put3(11, 3, 0, 16'hFFF0);
    put3(11, 1, 0, 16'hFFFF);
    emit(8'h00);
    start_run(0);
    wait_halt();
    @(negedge clk);
    chk("R8 reserved load reads zero", outv[0], 8'h00);
    chk("R8 reserved stores silent", outn, 1);
    chk("R8 no bus in reserved window", rsv_hits, 0);
    repeat (20) @(negedge clk);
    chk("R12 halted holds", halted, 1);
    chk("R12 no activity while halted", halt_acc, 0);

    // R6 input port stall
    clear_mem();
    put3(10, 0, 0, 16'hFFFF);
    put3(11, 0, 0, 16'hFFFF);
    emit(8'h00);
    in_valid = 1'b0;
    start_run(0);
    repeat (40) @(negedge clk);
    chk("R6 stalls without input", outn, 0);
    chk("R6 not halted while stalled", halted, 0);
    chk("R6 no ack without input", ack_n, 0);
    in_data = 8'h5C; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_halt();
    @(negedge clk);
    chk("R6 input byte loaded", outv[0], 8'h5C);
    chk("R6 single ack", ack_n, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule